// File: doc/BRIEF.md
# USB Full-Speed Packet Receiver

This block takes a full-speed USB line, already reduced to a single-ended level plus an SE0 indication, and turns it into packets. The line is oversampled with a clock that runs four times faster than the bit rate. A digital phase-locked loop recovers the bit strobes, and its sample point is moved back to mid-bit at every level change. The recovered bits then pass through a fixed chain of stages: sync search, NRZI decoding, removal of stuffed zeros, byte assembly, PID validation and CRC checking.

The first byte after sync is the PID. It is presented on its own port, with a one-cycle qualifier. Every later byte of the packet, the CRC field bytes included, is handed to a protocol layer through a one-byte holding register that has a valid/ready handshake. End-of-packet, PID failures, CRC failures, stuffing violations and holding-register overruns are each reported as single-cycle pulses.

Top module: `usb_fs_rx`

## Requirements
- R1: Bit timing is recovered from OVERSAMPLE (default 4) samples per bit. The sample point is realigned at every level or SE0 change, so bit periods of 3 to 5 samples decode correctly.
- R2: `line_i` = 1 is the J state and `se0_i` = 1 marks SE0. A packet begins after a run of seven level changes followed by one bit with no change (K J K J K J K K when starting from idle J).
- R3: In NRZI decoding, a bit with no level change is a 1 and a bit with a change is a 0. Bits are assembled least significant bit first.
- R4: After six consecutive 1 bits, the next bit is discarded. The trailing 1 of the sync counts toward the run. If that next bit is a 1, `stuff_err_o` pulses and the packet is abandoned: no further byte, PID or `eop_o` is produced until the line has passed through SE0.
- R5: The first byte after sync is the PID. If its upper nibble equals the bitwise complement of its lower nibble, `pid_valid_o` pulses and `pid_o` holds the lower nibble. Otherwise `pid_err_o` pulses, and the packet yields no bytes and no `eop_o`.
- R6: Every complete byte after a valid PID is delivered in order on `data_o`, including the bytes that carry the CRC field.
- R7: PIDs with lower bits 01 (tokens) are checked with CRC5 x^5+x^2+1, and the pass residue is 01100. PIDs with lower bits 11 (data) are checked with CRC16 x^16+x^15+x^2+1, and the pass residue is 0x800D. Other PIDs are not checked. `crc_err_o` pulses together with `eop_o` on a residue mismatch or when a partial byte remains.
- R8: The first SE0 bit after a valid PID produces exactly one `eop_o` pulse.
- R9: Once `data_valid_o` is high, it stays high and `data_o` stays unchanged until a cycle in which `data_ready_i` is high.
- R10: If a byte completes while the holding register is full and is not being emptied in that cycle, `overrun_o` pulses, the new byte is dropped, and the held byte is kept.
- R11: During and straight after reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock (4x bit rate) |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Single-ended line level, 1 = J |
| se0_i | input | 1 | High while both data lines are low |
| data_ready_i | input | 1 | Consumer accepts the held byte |
| pid_o | output | 4 | PID type nibble of the current packet |
| pid_valid_o | output | 1 | One-cycle pulse: valid PID received |
| data_o | output | 8 | Byte in the holding register |
| data_valid_o | output | 1 | Holding register is full |
| eop_o | output | 1 | One-cycle end-of-packet pulse |
| pid_err_o | output | 1 | PID check failed |
| crc_err_o | output | 1 | CRC check failed (with eop_o) |
| stuff_err_o | output | 1 | Seven consecutive ones seen |
| overrun_o | output | 1 | Byte dropped, register still full |

## Verification
A wrong phase in the recovery loop shows up as duplicated or lost bits. Within one byte time this corrupts the PID or a data byte, so the bench runs packets whose bit widths alternate between 3 and 5 samples. A wrong unstuffing count or NRZI polarity shows up at the byte port within eight bit times. It appears either as a changed byte or as a false stuffing error on payloads full of 0xFF. A wrong CRC register state shows up only at the `eop_o` pulse, so the bench sends a clean packet and a packet with one flipped bit. A holding register that loses track of being full shows up as a changed `data_o` or a missing `overrun_o` while the consumer stalls.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_BODY, ST_SKIP} rx_state_e;
  typedef enum logic [1:0] {PK_TOKEN, PK_DATA, PK_PLAIN} pkt_kind_e;

  localparam logic [7:0]  SYNC_PAT    = 8'h80;
  localparam logic [4:0]  CRC5_POLY   = 5'h05;
  localparam logic [4:0]  CRC5_RESID  = 5'b01100;
  localparam logic [15:0] CRC16_POLY  = 16'h8005;
  localparam logic [15:0] CRC16_RESID = 16'h800D;
  localparam int unsigned STUFF_RUN   = 6;

  function automatic logic [4:0] crc5_step(logic [4:0] c, logic b);
    logic fb;
    fb = b ^ c[4];
    return {c[3:0], 1'b0} ^ (fb ? CRC5_POLY : 5'h00);
  endfunction

  function automatic logic [15:0] crc16_step(logic [15:0] c, logic b);
    logic fb;
    fb = b ^ c[15];
    return {c[14:0], 1'b0} ^ (fb ? CRC16_POLY : 16'h0000);
  endfunction
endpackage

// File: rtl/usb_rx_dpll.sv
module usb_rx_dpll #(
  parameter int OVS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic se0_i,
  output logic bit_stb_o,
  output logic bit_lvl_o,
  output logic bit_se0_o
);
  localparam int PW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [PW-1:0] LAST   = PW'(OVS - 1);
  localparam logic [PW-1:0] CENTER = PW'(OVS / 2 - 1);

  logic [1:0] meta_q, sync_q, prev_q;
  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q    <= 2'b01;
      sync_q    <= 2'b01;
      prev_q    <= 2'b01;
      phase_q   <= '0;
      bit_stb_o <= 1'b0;
      bit_lvl_o <= 1'b1;
      bit_se0_o <= 1'b0;
    end else begin
      meta_q <= {se0_i, line_i};
      sync_q <= meta_q;
      prev_q <= sync_q;
      if (sync_q != prev_q || phase_q == LAST) phase_q <= '0;
      else                                     phase_q <= phase_q + 1'b1;
      bit_stb_o <= (sync_q == prev_q) && (phase_q == CENTER);
      bit_lvl_o <= sync_q[0];
      bit_se0_o <= sync_q[1];
    end
  end

  // R1: a realigned loop never yields two strobes in adjacent cycles
  p_strobe_gap_r1: assert property (@(posedge clk) disable iff (rst)
    bit_stb_o |=> !bit_stb_o);
endmodule

// File: rtl/usb_rx_decode.sv
module usb_rx_decode
  import usb_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_stb,
  input  logic       bit_lvl,
  input  logic       bit_se0,
  output logic [7:0] byte_o,
  output logic       byte_stb_o,
  output logic [3:0] pid_o,
  output logic       pid_stb_o,
  output logic       eop_o,
  output logic       pid_err_o,
  output logic       crc_err_o,
  output logic       stuff_err_o
);
  rx_state_e st_q;
  pkt_kind_e kind_q;
  logic       prev_lvl_q, got_pid_q;
  logic [7:0] hunt_q, sh_q;
  logic [2:0] ones_q, nb_q;
  logic [4:0] crc5_q;
  logic [15:0] crc16_q;

  logic       dec, crc_bad;
  logic [7:0] hunt_nx, sh_nx;

  always_comb begin
    dec     = (bit_lvl == prev_lvl_q);
    hunt_nx = {dec, hunt_q[7:1]};
    sh_nx   = {dec, sh_q[7:1]};
    case (kind_q)
      PK_TOKEN: crc_bad = (crc5_q != CRC5_RESID);
      PK_DATA:  crc_bad = (crc16_q != CRC16_RESID);
      default:  crc_bad = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_HUNT; kind_q <= PK_PLAIN;
      prev_lvl_q <= 1'b1; got_pid_q <= 1'b0;
      hunt_q <= '1; sh_q <= '0; ones_q <= '0; nb_q <= '0;
      crc5_q <= '1; crc16_q <= '1;
      byte_o <= '0; byte_stb_o <= 1'b0; pid_o <= '0; pid_stb_o <= 1'b0;
      eop_o <= 1'b0; pid_err_o <= 1'b0; crc_err_o <= 1'b0; stuff_err_o <= 1'b0;
    end else begin
      byte_stb_o <= 1'b0; pid_stb_o <= 1'b0; eop_o <= 1'b0;
      pid_err_o <= 1'b0; crc_err_o <= 1'b0; stuff_err_o <= 1'b0;
      if (bit_stb) begin
        if (!bit_se0) prev_lvl_q <= bit_lvl;
        case (st_q)
          ST_HUNT: begin
            if (bit_se0) hunt_q <= '1;
            else begin
              hunt_q <= hunt_nx;
              if (hunt_nx == SYNC_PAT) begin
                st_q <= ST_BODY; ones_q <= 3'd1; nb_q <= '0;
                got_pid_q <= 1'b0; crc5_q <= '1; crc16_q <= '1;
              end
            end
          end
          ST_BODY: begin
            if (bit_se0) begin
              st_q   <= ST_HUNT;
              hunt_q <= '1;
              if (got_pid_q) begin
                eop_o     <= 1'b1;
                crc_err_o <= crc_bad || (nb_q != 3'd0);
              end
            end else if (ones_q == 3'(STUFF_RUN)) begin
              ones_q <= '0;
              if (dec) begin
                stuff_err_o <= 1'b1;
                st_q        <= ST_SKIP;
              end
            end else begin
              ones_q <= dec ? ones_q + 1'b1 : 3'd0;
              sh_q   <= sh_nx;
              nb_q   <= nb_q + 1'b1;
              if (got_pid_q) begin
                crc5_q  <= crc5_step(crc5_q, dec);
                crc16_q <= crc16_step(crc16_q, dec);
              end
              if (nb_q == 3'd7) begin
                if (got_pid_q) begin
                  byte_o     <= sh_nx;
                  byte_stb_o <= 1'b1;
                end else if (sh_nx[7:4] == ~sh_nx[3:0]) begin
                  pid_o     <= sh_nx[3:0];
                  pid_stb_o <= 1'b1;
                  got_pid_q <= 1'b1;
                  case (sh_nx[1:0])
                    2'b01:   kind_q <= PK_TOKEN;
                    2'b11:   kind_q <= PK_DATA;
                    default: kind_q <= PK_PLAIN;
                  endcase
                end else begin
                  pid_err_o <= 1'b1;
                  st_q      <= ST_SKIP;
                end
              end
            end
          end
          default: begin
            if (bit_se0) begin
              st_q   <= ST_HUNT;
              hunt_q <= '1;
            end
          end
        endcase
      end
    end
  end

  // R7: a CRC verdict is only ever given together with end-of-packet
  p_crc_with_eop_r7: assert property (@(posedge clk) disable iff (rst)
    crc_err_o |-> eop_o);
  // R5: PID accept, PID reject, stuffing abort and EOP never coincide
  p_events_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pid_stb_o, pid_err_o, stuff_err_o, eop_o}));
  // R4: an aborted packet produces no byte or EOP right after the abort
  p_stuff_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    stuff_err_o |=> (!byte_stb_o && !eop_o));
endmodule

// File: rtl/usb_rx_holdbuf.sv
module usb_rx_holdbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         push,
  input  logic         ready,
  output logic [W-1:0] dout,
  output logic         valid,
  output logic         ovr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      valid <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      ovr <= 1'b0;
      if (push) begin
        if (valid && !ready) ovr <= 1'b1;
        else begin
          dout  <= din;
          valid <= 1'b1;
        end
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end

  // R9: a held byte stays offered until taken
  p_hold_valid_r9: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(dout)));
  // R10: a late consumer loses the new byte, not the held one
  p_overrun_keep_r10: assert property (@(posedge clk) disable iff (rst)
    (push && valid && !ready) |=> (ovr && $stable(dout)));
endmodule

// File: rtl/usb_fs_rx.sv
module usb_fs_rx #(
  parameter int OVERSAMPLE = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_i,
  input  logic       se0_i,
  input  logic       data_ready_i,
  output logic [3:0] pid_o,
  output logic       pid_valid_o,
  output logic [7:0] data_o,
  output logic       data_valid_o,
  output logic       eop_o,
  output logic       pid_err_o,
  output logic       crc_err_o,
  output logic       stuff_err_o,
  output logic       overrun_o
);
  logic       bit_stb, bit_lvl, bit_se0;
  logic [7:0] byte_w;
  logic       byte_stb;

  usb_rx_dpll #(.OVS(OVERSAMPLE)) u_dpll (
    .clk(clk), .rst(rst), .line_i(line_i), .se0_i(se0_i),
    .bit_stb_o(bit_stb), .bit_lvl_o(bit_lvl), .bit_se0_o(bit_se0)
  );

  usb_rx_decode u_dec (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_lvl(bit_lvl), .bit_se0(bit_se0),
    .byte_o(byte_w), .byte_stb_o(byte_stb), .pid_o(pid_o), .pid_stb_o(pid_valid_o),
    .eop_o(eop_o), .pid_err_o(pid_err_o), .crc_err_o(crc_err_o),
    .stuff_err_o(stuff_err_o)
  );

  usb_rx_holdbuf #(.W(8)) u_hold (
    .clk(clk), .rst(rst), .din(byte_w), .push(byte_stb), .ready(data_ready_i),
    .dout(data_o), .valid(data_valid_o), .ovr(overrun_o)
  );
endmodule

// File: tb/sim_usb_fs_rx.sv
module sim_usb_fs_rx;
  logic clk = 1'b0, rst = 1'b1, line = 1'b1, se0 = 1'b0, rdy = 1'b1;
  logic [3:0] pid_o;
  logic [7:0] data_o;
  logic pid_valid_o, data_valid_o, eop_o, pid_err_o, crc_err_o, stuff_err_o, overrun_o;

  always #4 clk = ~clk;

  usb_fs_rx u0 (
    .clk(clk), .rst(rst), .line_i(line), .se0_i(se0), .data_ready_i(rdy),
    .pid_o(pid_o), .pid_valid_o(pid_valid_o), .data_o(data_o),
    .data_valid_o(data_valid_o), .eop_o(eop_o), .pid_err_o(pid_err_o),
    .crc_err_o(crc_err_o), .stuff_err_o(stuff_err_o), .overrun_o(overrun_o)
  );

  int checks = 0, fails = 0;
  int n_bytes, n_pid, n_perr, n_eop, n_crc, n_stuff, n_ovr;
  logic [3:0] last_pid;
  logic [7:0] got [0:63];
  bit pkt[$];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    if (pid_valid_o) begin n_pid++; last_pid = pid_o; end
    if (pid_err_o) n_perr++;
    if (eop_o) n_eop++;
    if (crc_err_o) n_crc++;
    if (stuff_err_o) n_stuff++;
    if (overrun_o) n_ovr++;
    if (data_valid_o && rdy) begin
      if (n_bytes < 64) got[n_bytes] = data_o;
      n_bytes++;
    end
  end

  task automatic clear_mon();
    n_bytes = 0; n_pid = 0; n_perr = 0; n_eop = 0; n_crc = 0; n_stuff = 0; n_ovr = 0;
    last_pid = 4'h0;
    pkt.delete();
  endtask

  task automatic add_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) pkt.push_back(b[i]);
  endtask

  task automatic add_crc5();
    logic [4:0] c = 5'h1F;
    for (int i = 8; i < pkt.size(); i++) begin
      bit fb = pkt[i] ^ c[4];
      c = {c[3:0], 1'b0};
      if (fb) c = c ^ 5'h05;
    end
    for (int i = 4; i >= 0; i--) pkt.push_back(~c[i]);
  endtask

  task automatic add_crc16();
    logic [15:0] c = 16'hFFFF;
    for (int i = 8; i < pkt.size(); i++) begin
      bit fb = pkt[i] ^ c[15];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h8005;
    end
    for (int i = 15; i >= 0; i--) pkt.push_back(~c[i]);
  endtask

  bit jit_phase = 0;
  task automatic put(input logic l, input logic s, input bit jit);
    int n = 4;
    if (jit) begin n = jit_phase ? 5 : 3; jit_phase = ~jit_phase; end
    line = l; se0 = s;
    repeat (n) @(negedge clk);
  endtask

  // NRZI-encode the sync and the queued bits, stuffing if asked, then EOP
  task automatic tx(input bit do_stuff, input bit jit);
    logic lvl = 1'b1;
    int ones = 1;
    for (int i = 0; i < 4; i++) put(1'b1, 1'b0, jit);
    for (int i = 0; i < 7; i++) begin lvl = ~lvl; put(lvl, 1'b0, jit); end
    put(lvl, 1'b0, jit);
    for (int i = 0; i < pkt.size(); i++) begin
      if (!pkt[i]) lvl = ~lvl;
      put(lvl, 1'b0, jit);
      ones = pkt[i] ? ones + 1 : 0;
      if (do_stuff && ones == 6) begin lvl = ~lvl; put(lvl, 1'b0, jit); ones = 0; end
    end
    put(1'b0, 1'b1, jit); put(1'b0, 1'b1, jit);
    for (int i = 0; i < 5; i++) put(1'b1, 1'b0, jit);
    repeat (20) @(negedge clk);
  endtask

  task automatic check_bytes(input string req);
    int nexp = (pkt.size() - 8) / 8;
    chk(n_bytes == nexp, req, n_bytes, nexp);
    for (int k = 0; k < nexp && k < n_bytes; k++) begin
      logic [7:0] e;
      for (int j = 0; j < 8; j++) e[j] = pkt[8 + 8*k + j];
      chk(got[k] == e, req, got[k], e);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk({pid_valid_o, data_valid_o, eop_o, pid_err_o, crc_err_o, stuff_err_o, overrun_o} == 7'b0,
        "R11", {pid_valid_o, data_valid_o, eop_o, pid_err_o}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk({pid_valid_o, data_valid_o, eop_o, overrun_o} == 4'b0, "R11", data_valid_o, 0);
  endtask

  task automatic t_token(input bit jit, input string req);
    clear_mon();
    add_byte(8'hE1);
    for (int i = 0; i < 7; i++) pkt.push_back(i % 3 == 0);
    for (int i = 0; i < 4; i++) pkt.push_back(i[0]);
    add_crc5();
    tx(1'b1, jit);
    chk(n_pid == 1 && last_pid == 4'h1, req, last_pid, 1);
    check_bytes(req);
    chk(n_eop == 1, "R8", n_eop, 1);
    chk(n_crc == 0, "R7", n_crc, 0);
  endtask

  task automatic t_data(input bit corrupt);
    clear_mon();
    add_byte(8'hC3);
    add_byte(8'h3C); add_byte(8'hFF); add_byte(8'hFF); add_byte(8'h00); add_byte(8'hA5);
    add_crc16();
    if (corrupt) pkt[20] = ~pkt[20];
    tx(1'b1, 1'b0);
    chk(last_pid == 4'h3, "R5", last_pid, 3);
    check_bytes("R4 R6");
    chk(n_stuff == 0, "R4", n_stuff, 0);
    chk(n_eop == 1, "R8", n_eop, 1);
    chk(n_crc == (corrupt ? 1 : 0), "R7", n_crc, corrupt);
  endtask

  task automatic t_ack();
    clear_mon();
    add_byte(8'hD2);
    tx(1'b1, 1'b0);
    chk(n_pid == 1 && last_pid == 4'h2, "R5", last_pid, 2);
    chk(n_eop == 1 && n_crc == 0 && n_bytes == 0, "R7", n_crc, 0);
  endtask

  task automatic t_bad_pid();
    clear_mon();
    add_byte(8'h21); add_byte(8'h55); add_byte(8'h66);
    tx(1'b1, 1'b0);
    chk(n_perr == 1, "R5", n_perr, 1);
    chk(n_pid == 0 && n_bytes == 0 && n_eop == 0, "R5", n_bytes + n_eop, 0);
  endtask

  task automatic t_stuff_err();
    clear_mon();
    add_byte(8'hC3); add_byte(8'hFF); add_byte(8'h12);
    tx(1'b0, 1'b0);
    chk(n_stuff == 1, "R4", n_stuff, 1);
    chk(n_bytes == 0 && n_eop == 0, "R4", n_bytes + n_eop, 0);
  endtask

  task automatic t_overrun();
    clear_mon();
    rdy = 1'b0;
    add_byte(8'h4B); add_byte(8'h11); add_byte(8'h22); add_byte(8'h33);
    add_crc16();
    tx(1'b1, 1'b0);
    chk(data_valid_o == 1'b1, "R9", data_valid_o, 1);
    chk(data_o == 8'h11, "R10", data_o, 8'h11);
    chk(n_ovr == 4, "R10", n_ovr, 4);
    rdy = 1'b1;
    repeat (3) @(negedge clk);
    chk(n_bytes == 1 && got[0] == 8'h11, "R9", got[0], 8'h11);
    chk(data_valid_o == 1'b0, "R9", data_valid_o, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_token(1'b0, "R2 R3 R6");
    t_token(1'b1, "R1");
    t_data(1'b0);
    t_data(1'b1);
    t_ack();
    t_bad_pid();
    t_stuff_err();
    t_overrun();
    t_token(1'b0, "R2");
    finish_run();
  end
endmodule